// File: doc/BRIEF.md
# Converter Serial Readout Sequencer

This block sequences a converter that works in repeating cycles and sends each result over a three-wire serial link. After reset it asks a conversion engine to start. When the engine reports a result, the block captures it in a shift register and sleeps. A host pulls an active-low select line low to read the result. The host then supplies a serial clock, samples each bit on the rising edge and the block advances on the falling edge. Once the whole word has gone out, or once the host releases the select after it has begun clocking, the block starts a fresh conversion.

No register sets the operating mode. The readout is controlled only by when the select line changes relative to the first rising serial-clock edge. If the select is released before that edge, the read is cancelled harmlessly: the block goes back to sleep and keeps the result for a later read. If it is released after that edge, the readout is abandoned and a new conversion begins. Both host lines are brought into the system clock domain through two-flop synchronisers, and serial-clock edges are found by comparing each synchronised sample with the one before it.

Top module: `adc_readout_seq`

## Requirements
- R1: During and after reset the phase output reads 0 (convert) and `sdo` reads 1. `conv_start` pulses high for exactly one system clock shortly after reset is released.
- R2: In the convert phase, a `conv_done` pulse loads `conv_result` into the shift register and moves the phase to 1 (sleep). A `conv_done` pulse in any other phase changes neither the stored result nor the phase.
- R3: In sleep with the select high, the phase stays at 1 and the stored result stays unchanged for any length of time.
- R4: A synchronised low on `cs_n` during sleep moves the phase to 2 (output). The most significant result bit appears on `sdo` before any serial-clock edge.
- R5: If `cs_n` goes high in the output phase before the first synchronised rising `sclk` edge, the phase returns to 1 with the result intact. The next read then delivers the same word from its first bit, and no `conv_start` is issued.
- R6: Bits leave most significant first. `sdo` advances by one bit only on a synchronised falling `sclk` edge that comes after the first rising edge, so a host that samples before each rising edge receives the stored word.
- R7: On the falling `sclk` edge that completes the RESULT_W-th bit after the first rising edge, the phase returns to 0 and `conv_start` pulses for one clock.
- R8: If `cs_n` goes high in the output phase after the first rising `sclk` edge, the readout stops, the phase returns to 0 and `conv_start` pulses for one clock.
- R9: Outside the output phase, `sdo` sits at the idle level 1.
- R10: The phase follows only the transitions convert to sleep, sleep to output, output to convert and output to sleep. Phase encoding: 0 is convert, 1 is sleep, 2 is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| conv_done | input | 1 | One-cycle pulse from the conversion engine: result valid |
| conv_result | input | RESULT_W | Result word from the conversion engine |
| sdo | output | 1 | Serial data out, idle level 1 |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| phase_o | output | 2 | Current phase: 0 convert, 1 sleep, 2 output |

## Verification
On every cycle, the assertions check the legal phase transitions and the idle level of `sdo` outside the output phase. They also check that the stored word does not change while the block sleeps, that `sdo` moves only after a synchronised falling serial-clock edge, that a done pulse during conversion always leads to sleep, and that the conversion request is a single-cycle pulse seen only in the convert phase. Other behaviours can only be shown by the bench's scenarios, which reassemble whole words from the serial stream. These are the most-significant-first order, the split between a cancelled read and an abandoned one around the first rising edge, completion after exactly RESULT_W bits, and a done pulse arriving outside the convert phase being ignored.

// File: rtl/adc_rdo_pkg.sv
package adc_rdo_pkg;

  typedef enum logic [1:0] {
    PH_CONVERT = 2'd0,
    PH_SLEEP   = 2'd1,
    PH_OUTPUT  = 2'd2
  } phase_e;

  // True when a falling edge at bit index idx finishes a word of width w.
  function automatic logic is_final_fall(input int unsigned idx, input int unsigned w);
    return idx == w - 1;
  endfunction

endpackage

// File: rtl/rdo_sync_edge.sv
module rdo_sync_edge #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= RESET_VAL;
    else        chain_q[0] <= async_in;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RESET_VAL;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RESET_VAL;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;
  assign fall  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/rdo_shifter.sv
module rdo_shifter #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift,
  output logic [WIDTH-1:0] data_q,
  output logic             msb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (load)  data_q <= load_val;
    else if (shift) data_q <= {data_q[WIDTH-2:0], 1'b0};
  end

  assign msb = data_q[WIDTH-1];
endmodule

// File: rtl/rdo_phase_fsm.sv
module rdo_phase_fsm
  import adc_rdo_pkg::*;
#(
  parameter int unsigned WIDTH = 24
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   conv_done,
  input  logic   cs_lvl,
  input  logic   sclk_rise,
  input  logic   sclk_fall,
  output phase_e phase,
  output logic   load,
  output logic   shift,
  output logic   conv_start
);
  localparam int unsigned CNT_W = $clog2(WIDTH + 1);

  logic             seen_rise_q;
  logic [CNT_W-1:0] fall_cnt_q;
  logic             kick_q;

  assign load  = (phase == PH_CONVERT) && conv_done;
  assign shift = (phase == PH_OUTPUT) && !cs_lvl && sclk_fall && seen_rise_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_CONVERT;
      seen_rise_q <= 1'b0;
      fall_cnt_q  <= '0;
      kick_q      <= 1'b1;
      conv_start  <= 1'b0;
    end else begin
      conv_start <= kick_q;
      kick_q     <= 1'b0;
      case (phase)
        PH_CONVERT: if (conv_done) phase <= PH_SLEEP;
        PH_SLEEP: if (!cs_lvl) begin
          phase       <= PH_OUTPUT;
          seen_rise_q <= 1'b0;
          fall_cnt_q  <= '0;
        end
        PH_OUTPUT: begin
          if (cs_lvl) begin
            if (seen_rise_q) begin
              phase      <= PH_CONVERT;
              conv_start <= 1'b1;
            end else begin
              phase <= PH_SLEEP;
            end
          end else begin
            if (sclk_rise) seen_rise_q <= 1'b1;
            if (shift) begin
              fall_cnt_q <= fall_cnt_q + 1'b1;
              if (is_final_fall(int'(fall_cnt_q), WIDTH)) begin
                phase      <= PH_CONVERT;
                conv_start <= 1'b1;
              end
            end
          end
        end
        default: phase <= PH_CONVERT;
      endcase
    end
  end
endmodule

// File: rtl/adc_readout_seq.sv
module adc_readout_seq
  import adc_rdo_pkg::*;
#(
  parameter int unsigned RESULT_W    = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                conv_done,
  input  logic [RESULT_W-1:0] conv_result,
  output logic                sdo,
  output logic                conv_start,
  output logic [1:0]          phase_o
);
  logic                cs_lvl, cs_rise, cs_fall;
  logic                sclk_lvl, sclk_rise, sclk_fall;
  logic                load, shift, msb;
  logic [RESULT_W-1:0] shreg_q;
  phase_e              phase;

  rdo_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cs_n),
    .level(cs_lvl), .rise(cs_rise), .fall(cs_fall)
  );

  rdo_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sclk),
    .level(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall)
  );

  rdo_phase_fsm #(.WIDTH(RESULT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .cs_lvl(cs_lvl),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .phase(phase),
    .load(load), .shift(shift), .conv_start(conv_start)
  );

  rdo_shifter #(.WIDTH(RESULT_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(conv_result),
    .shift(shift), .data_q(shreg_q), .msb(msb)
  );

  // Edge and level views not used by the sequencing itself.
  logic unused_sync;
  assign unused_sync = cs_rise ^ cs_fall ^ sclk_lvl;

  assign sdo     = (phase == PH_OUTPUT) ? msb : 1'b1;
  assign phase_o = phase;
endmodule

// File: rtl/adc_readout_chk.sv
module adc_readout_chk #(
  parameter int unsigned RESULT_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                conv_done,
  input logic                sclk_fall,
  input logic [1:0]          phase_o,
  input logic [RESULT_W-1:0] shreg_q,
  input logic                sdo,
  input logic                conv_start
);
  p_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) |->
      (($past(phase_o) == 2'd0 && phase_o == 2'd1) ||
       ($past(phase_o) == 2'd1 && phase_o == 2'd2) ||
       ($past(phase_o) == 2'd2 && (phase_o == 2'd0 || phase_o == 2'd1))));

  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != 2'd2) |-> sdo);

  p_sleep_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd1 && $past(phase_o) == 2'd1) |-> $stable(shreg_q));

  p_shift_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd2 && $past(phase_o) == 2'd2 && !$past(sclk_fall)) |-> $stable(sdo));

  p_done_to_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd0 && conv_done) |=> (phase_o == 2'd1));

  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (phase_o == 2'd0));

  p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
endmodule

bind adc_readout_seq adc_readout_chk #(.RESULT_W(RESULT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .sclk_fall(sclk_fall),
  .phase_o(phase_o), .shreg_q(shreg_q), .sdo(sdo), .conv_start(conv_start)
);

// File: tb/adc_readout_seq_test.sv
module adc_readout_seq_test;
  localparam int W = 24;
  localparam int NVEC = 6;
  // {mode[1:0], bits_before_release[5:0], result[23:0]}
  // mode 0: full read; mode 1: cancelled read then full read; mode 2: abandoned after k bits
  localparam logic [31:0] VEC [NVEC] = '{
    {2'd0, 6'd0,  24'hA5C3F1},
    {2'd1, 6'd0,  24'h800001},
    {2'd2, 6'd5,  24'h3C5A96},
    {2'd0, 6'd0,  24'hFFFFFF},
    {2'd2, 6'd1,  24'h000000},
    {2'd1, 6'd0,  24'h7E1234}
  };

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, conv_done = 0;
  logic [W-1:0] conv_result = '0;
  logic sdo, conv_start;
  logic [1:0] phase_o;
  int checks = 0, failures = 0, start_cnt = 0;
  logic [W-1:0] got;

  always #4 clk = ~clk;

  adc_readout_seq #(.RESULT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .conv_done(conv_done),
    .conv_result(conv_result), .sdo(sdo), .conv_start(conv_start), .phase_o(phase_o)
  );

  always @(negedge clk) if (conv_start) start_cnt++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_conv(input logic [W-1:0] val);
    @(negedge clk); conv_result = val; conv_done = 1;
    @(negedge clk); conv_done = 0; conv_result = '0;
  endtask

  // Samples one bit before each rising edge, then issues a rise and a fall.
  task automatic read_bits(input int n);
    for (int i = 0; i < n; i++) begin
      got[W-1-i] = sdo;
      sclk = 1; waitc(6);
      sclk = 0; waitc(6);
    end
  endtask

  task automatic full_read(input logic [W-1:0] val);
    int s0;
    cs_n = 0; waitc(6);
    check(phase_o == 2'd2, "R4 enter output", 32'(phase_o), 2);
    check(sdo == val[W-1], "R4 msb before first rise", 32'(sdo), 32'(val[W-1]));
    s0 = start_cnt;
    got = '0;
    read_bits(W);
    check(got == val, "R6 msb-first word", 32'(got), 32'(val));
    check(phase_o == 2'd0, "R7 done after full word", 32'(phase_o), 0);
    check(start_cnt == s0 + 1, "R7 conv_start once", 32'(start_cnt - s0), 1);
    cs_n = 1; waitc(6);
    check(sdo == 1'b1, "R9 idle after read", 32'(sdo), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    waitc(3);
    check(phase_o == 2'd0, "R1 phase in reset", 32'(phase_o), 0);
    check(sdo == 1'b1, "R1 sdo in reset", 32'(sdo), 1);
    rst_n = 1;
    waitc(4);
    check(start_cnt == 1, "R1 one start after reset", 32'(start_cnt), 1);

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] mode;
      int k, s0;
      logic [W-1:0] val;
      mode = VEC[v][31:30];
      k = int'(VEC[v][29:24]);
      val = VEC[v][23:0];
      finish_conv(val);
      waitc(1);
      check(phase_o == 2'd1, "R2 sleep after done", 32'(phase_o), 1);
      waitc(40);
      check(phase_o == 2'd1, "R3 stays asleep", 32'(phase_o), 1);
      check(sdo == 1'b1, "R9 idle in sleep", 32'(sdo), 1);
      if (mode == 2'd1) begin
        s0 = start_cnt;
        cs_n = 0; waitc(6);
        check(phase_o == 2'd2, "R4 enter output", 32'(phase_o), 2);
        cs_n = 1; waitc(6);
        check(phase_o == 2'd1, "R5 cancel returns to sleep", 32'(phase_o), 1);
        check(start_cnt == s0, "R5 no start on cancel", 32'(start_cnt - s0), 0);
        full_read(val);
      end else if (mode == 2'd2) begin
        cs_n = 0; waitc(6);
        s0 = start_cnt;
        got = '0;
        read_bits(k);
        cs_n = 1; waitc(6);
        check(phase_o == 2'd0, "R8 abort to convert", 32'(phase_o), 0);
        check(start_cnt == s0 + 1, "R8 start on abort", 32'(start_cnt - s0), 1);
        check((got >> (W - k)) == (val >> (W - k)), "R6 partial bits", 32'(got), 32'(val));
      end else begin
        full_read(val);
      end
    end

    // Directed: long sleep, then done pulses in sleep and output are ignored.
    finish_conv(24'hC0FFEE);
    waitc(600);
    check(phase_o == 2'd1, "R3 long sleep", 32'(phase_o), 1);
    finish_conv(24'h123456);
    waitc(2);
    check(phase_o == 2'd1, "R2 done ignored in sleep", 32'(phase_o), 1);
    cs_n = 0; waitc(6);
    finish_conv(24'h0F0F0F);
    waitc(2);
    check(phase_o == 2'd2, "R2 done ignored in output", 32'(phase_o), 2);
    check(sdo == 1'b1, "R2 msb unchanged", 32'(sdo), 1);
    cs_n = 1; waitc(6);
    check(phase_o == 2'd1, "R10 output back to sleep", 32'(phase_o), 1);
    full_read(24'hC0FFEE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule